// File: doc/BRIEF.md
# Static Seven-Segment Display Driver

This block turns a three-and-a-half-digit BCD reading into static segment drive for a display with no multiplexing. Each segment has its own output line. The three low digits get seven lines each. The leading half digit is a single line that lights both of its segments, so it can show only a "1". The minus sign has its own line.

The block has two drive modes:
- **LCD mode.** An internal square-wave backplane is generated. Every segment line is the backplane for an unlit segment and the inverted backplane for a lit one. Each segment therefore sees only AC across it.
- **LED mode.** Lit segments are pulled low, as a common-anode display needs, and the backplane is held low.

The backplane half period is a parameter, `BP_HALF`, given in clock cycles. With a 16000-clock conversion cycle, a value of 400 gives twenty backplane periods per conversion. The reading, the flags and the mode are captured only at backplane edges. Segment lines therefore never change in the middle of a backplane phase.

Top module: `seg_static_drv`

## Requirements
- R1: While reset is asserted, and until the first backplane edge after it, every segment line, the lead line, the minus line and `backplane` are 0, and the drive mode is LCD.
- R2: Once the reset release has been synchronised (two clock edges), the internal backplane toggles every `BP_HALF` clock cycles. In LCD mode it appears on `backplane`.
- R3: In LCD mode, each output line equals its on/off state XOR `backplane`. An unlit line is in phase with the backplane; a lit line is in antiphase.
- R4: Digit i of `bcd_digits` (bits 4i+3:4i, digit 0 = units) drives `seg_digits` bits 7i+6:7i, with bit 0 = a through bit 6 = g. Codes 0 to 9 use the standard patterns 3F,06,5B,4F,66,6D,7D,07,7F,6F (hex, 1 = lit).
- R5: BCD codes 10 to 15 blank their digit.
- R6: The lead line is lit exactly when `lead_one` is 1.
- R7: The minus line is lit exactly when `neg` is 1 (1 = negative reading).
- R8: When `ovr` is 1, all low digits are blank. The lead line and the minus line still follow their inputs.
- R9: With `lcd_mode` = 0 (LED mode), lit lines are driven 0, unlit lines are driven 1, and `backplane` is 0.
- R10: The digits, flags and mode are sampled only on the clock edge where the backplane toggles. Input changes between those edges have no effect on any output until the next toggle.
- R11: A change of `lcd_mode` takes effect at the next backplane toggle, never inside a phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lcd_mode | input | 1 | 1 = LCD drive, 0 = common-anode LED drive |
| bcd_digits | input | 4*NUM_DIG | Low digits in BCD, units in the lowest nibble |
| lead_one | input | 1 | Leading half digit shows "1" |
| neg | input | 1 | Reading is negative |
| ovr | input | 1 | Overrange: blank the low digits |
| seg_digits | output | 7*NUM_DIG | Segment lines, 7 per digit, bit 0 = a |
| seg_lead | output | 1 | Line driving both segments of the half digit |
| seg_minus | output | 1 | Minus-sign line |
| backplane | output | 1 | LCD backplane square wave, held 0 in LED mode |

## Verification
The assertions assume that the flags and digits are driven synchronously and hold steady across each clock edge. They compare outputs after a backplane toggle against the inputs in the cycle before it, so an input that changes exactly at a toggle edge is counted as the new value. The bench drives every input on the falling edge. It changes the digits, the flags and the mode both in the middle of a phase and just before a toggle. It uses a short backplane half period so that many phases pass in a short run.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;
  localparam int SEG_N = 7;

  // segment bit 0 = a ... bit 6 = g, 1 = lit
  function automatic logic [SEG_N-1:0] bcd_to_seg(input logic [3:0] code);
    logic [SEG_N-1:0] s;
    case (code)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_s  <= meta_q;
    end
  end
endmodule

// File: rtl/seg_phase_gen.sv
module seg_phase_gen #(
  parameter int BP_HALF = 400
) (
  input  logic clk,
  input  logic rst_s,
  output logic bp_q,
  output logic tick
);
  localparam int CNT_W = (BP_HALF > 2) ? $clog2(BP_HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BP_HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bp_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    bp_d  = bp_q;
    if (tick) begin
      cnt_d = '0;
      bp_d  = ~bp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cnt_q <= '0;
      bp_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      bp_q  <= bp_d;
    end
  end
endmodule

// File: rtl/seg_digit_dec.sv
module seg_digit_dec
  import seg_drv_pkg::*;
#(
  parameter int NUM_DIG = 3
) (
  input  logic [4*NUM_DIG-1:0]     bcd,
  input  logic                     blank,
  output logic [SEG_N*NUM_DIG-1:0] segs
);
  for (genvar i = 0; i < NUM_DIG; i++) begin : g_dig
    assign segs[SEG_N*i +: SEG_N] = blank ? '0 : bcd_to_seg(bcd[4*i +: 4]);
  end
endmodule

// File: rtl/seg_static_drv.sv
module seg_static_drv
  import seg_drv_pkg::*;
#(
  parameter int NUM_DIG = 3,
  parameter int BP_HALF = 400
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lcd_mode,
  input  logic [4*NUM_DIG-1:0]     bcd_digits,
  input  logic                     lead_one,
  input  logic                     neg,
  input  logic                     ovr,
  output logic [SEG_N*NUM_DIG-1:0] seg_digits,
  output logic                     seg_lead,
  output logic                     seg_minus,
  output logic                     backplane
);
  localparam int DSEG = SEG_N * NUM_DIG;

  logic            rst_s;
  logic            bp_q;
  logic            tick;
  logic [DSEG-1:0] dec_segs;

  logic [DSEG-1:0] pat_dig_q, pat_dig_d;
  logic            lead_q, lead_d;
  logic            minus_q, minus_d;
  logic            mode_q, mode_d;

  seg_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  seg_phase_gen #(.BP_HALF(BP_HALF)) u_phase (
    .clk   (clk),
    .rst_s (rst_s),
    .bp_q  (bp_q),
    .tick  (tick)
  );

  seg_digit_dec #(.NUM_DIG(NUM_DIG)) u_dec (
    .bcd   (bcd_digits),
    .blank (ovr),
    .segs  (dec_segs)
  );

  // capture only on backplane edges
  always_comb begin
    pat_dig_d = pat_dig_q;
    lead_d    = lead_q;
    minus_d   = minus_q;
    mode_d    = mode_q;
    if (tick) begin
      pat_dig_d = dec_segs;
      lead_d    = lead_one;
      minus_d   = neg;
      mode_d    = lcd_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pat_dig_q <= '0;
      lead_q    <= 1'b0;
      minus_q   <= 1'b0;
      mode_q    <= 1'b1;
    end else begin
      pat_dig_q <= pat_dig_d;
      lead_q    <= lead_d;
      minus_q   <= minus_d;
      mode_q    <= mode_d;
    end
  end

  // LCD: lit = antiphase to backplane; LED: lit = low
  assign seg_digits = mode_q ? (pat_dig_q ^ {DSEG{bp_q}}) : ~pat_dig_q;
  assign seg_lead   = mode_q ? (lead_q ^ bp_q)  : ~lead_q;
  assign seg_minus  = mode_q ? (minus_q ^ bp_q) : ~minus_q;
  assign backplane  = mode_q & bp_q;
endmodule

// File: rtl/seg_static_drv_chk.sv
module seg_static_drv_chk #(
  parameter int NUM_DIG = 3,
  parameter int BP_HALF = 400
) (
  input logic                 clk,
  input logic                 rst_s,
  input logic                 bp_q,
  input logic                 mode_q,
  input logic [7*NUM_DIG-1:0] pat_q,
  input logic                 neg_in,
  input logic                 ovr_in,
  input logic [7*NUM_DIG-1:0] seg_digits,
  input logic                 seg_minus,
  input logic                 backplane
);
  localparam int GW = (BP_HALF > 2) ? $clog2(BP_HALF) : 1;
  localparam logic [GW-1:0] GLAST = GW'(BP_HALF - 1);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) gap_q <= '0;
    else        gap_q <= (gap_q == GLAST) ? '0 : gap_q + 1'b1;
  end

  // R2
  bp_toggle_due_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (gap_q == GLAST) |=> !$stable(bp_q));

  // R2
  bp_toggle_early_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(bp_q) |-> (gap_q == '0));

  // R10
  pat_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(pat_q) |-> !$stable(bp_q));

  // R9
  led_bp_low_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !mode_q |-> (backplane == 1'b0));

  // R7
  minus_follow_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(bp_q) |-> ((mode_q ? (seg_minus ^ backplane) : ~seg_minus) == $past(neg_in)));

  // R8
  ovr_blank_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!$stable(bp_q) && $past(ovr_in)) |->
      (seg_digits == (mode_q ? {(7*NUM_DIG){backplane}} : {(7*NUM_DIG){1'b1}})));
endmodule

bind seg_static_drv seg_static_drv_chk #(.NUM_DIG(NUM_DIG), .BP_HALF(BP_HALF)) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .bp_q       (bp_q),
  .mode_q     (mode_q),
  .pat_q      (pat_dig_q),
  .neg_in     (neg),
  .ovr_in     (ovr),
  .seg_digits (seg_digits),
  .seg_minus  (seg_minus),
  .backplane  (backplane)
);

// File: tb/seg_static_drv_tb.sv
module seg_static_drv_tb;
  localparam int ND   = 3;
  localparam int HALF = 5;

  logic          clk;
  logic          rst_n;
  logic          lcd_mode;
  logic [4*ND-1:0] bcd_digits;
  logic          lead_one, neg, ovr;
  logic [7*ND-1:0] seg_digits;
  logic          seg_lead, seg_minus, backplane;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  string cur_req = "R1";

  seg_static_drv #(.NUM_DIG(ND), .BP_HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .lcd_mode(lcd_mode), .bcd_digits(bcd_digits),
    .lead_one(lead_one), .neg(neg), .ovr(ovr), .seg_digits(seg_digits),
    .seg_lead(seg_lead), .seg_minus(seg_minus), .backplane(backplane)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [6:0] ref_seg(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  // behavioural reference model
  int m_edges, m_cnt;
  logic m_bp, m_mode, m_lead, m_minus;
  logic [7*ND-1:0] m_dig;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_edges = 0; m_cnt = 0; m_bp = 0; m_mode = 1;
      m_lead = 0; m_minus = 0; m_dig = '0;
    end else begin
      m_edges++;
      if (m_edges >= 3) begin
        if (m_cnt == HALF - 1) begin
          m_cnt = 0;
          m_bp = ~m_bp;
          m_mode = lcd_mode;
          m_lead = lead_one;
          m_minus = neg;
          for (int i = 0; i < ND; i++)
            m_dig[7*i +: 7] = ovr ? 7'h00 : ref_seg(int'(bcd_digits[4*i +: 4]));
        end else begin
          m_cnt++;
        end
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [7*ND-1:0] e_dig;
    logic e_lead, e_minus, e_bp;
    e_bp    = m_mode & m_bp;
    e_dig   = m_mode ? (m_dig ^ {(7*ND){m_bp}}) : ~m_dig;
    e_lead  = m_mode ? (m_lead ^ m_bp) : ~m_lead;
    e_minus = m_mode ? (m_minus ^ m_bp) : ~m_minus;
    check("R2", "backplane", 32'(backplane), 32'(e_bp));
    check(cur_req, "digits", 32'(seg_digits), 32'(e_dig));
    check("R6", "lead", 32'(seg_lead), 32'(e_lead));
    check("R7", "minus", 32'(seg_minus), 32'(e_minus));
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic set_in(input int h, input int t, input int u,
                        input logic one, input logic ng, input logic ov);
    bcd_digits = {4'(h), 4'(t), 4'(u)};
    lead_one = one; neg = ng; ovr = ov;
  endtask

  initial begin
    rst_n = 1'b0; lcd_mode = 1'b1;
    set_in(8, 8, 8, 1, 1, 0);
    // R1: reset state
    cur_req = "R1";
    step(4);
    rst_n = 1'b1;
    step(6);
    // R3/R4 LCD decode
    cur_req = "R3/R4";
    set_in(1, 2, 3, 0, 0, 0); step(12);
    set_in(4, 5, 6, 1, 1, 0); step(12);
    set_in(7, 8, 9, 1, 0, 0); step(12);
    set_in(0, 0, 0, 0, 1, 0); step(12);
    // R10: mid-phase changes
    cur_req = "R10";
    step(2);
    set_in(9, 3, 5, 1, 0, 0); step(1);
    set_in(2, 6, 4, 0, 1, 0); step(13);
    // R5 invalid codes
    cur_req = "R5";
    set_in(10, 15, 12, 1, 0, 0); step(12);
    set_in(3, 11, 13, 0, 1, 0); step(12);
    // R8 overrange
    cur_req = "R8";
    set_in(5, 5, 5, 1, 1, 1); step(12);
    set_in(0, 1, 2, 1, 0, 1); step(12);
    // R9/R11 LED mode, switched mid-phase
    cur_req = "R9/R11";
    step(2);
    lcd_mode = 1'b0;
    set_in(3, 4, 8, 1, 1, 0); step(14);
    set_in(6, 0, 7, 0, 0, 0); step(12);
    set_in(1, 1, 1, 1, 0, 1); step(12);
    // R11 back to LCD
    cur_req = "R11/R3";
    step(1);
    lcd_mode = 1'b1;
    set_in(2, 0, 9, 1, 1, 0); step(16);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule